// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block encodes an already-scrambled payload bit stream with a rate 1/2 convolutional code of constraint length 7. It can thin the coded stream to rate 2/3 or 3/4 by dropping coded bits in a fixed repeating pattern. Bits arrive one at a time on a valid/ready interface. A start flag marks the first bit of a packet and an end flag marks the last. The rate code is sampled together with the first bit and is held until the packet is finished.

When the last payload bit has been taken, the block feeds six zero tail bits through the encoder without further input. This returns the encoder to the all-zero state. The tail bits are punctured in the same way as the data. Coded bits leave one per cycle on a valid/ready interface, and the final coded bit of each packet carries an end flag. The core clock runs much faster than the sample rate, so both sides are paced by strobes and either side may stall at any time.

Top module: `conv_punct_enc`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Output A is the parity of the current bit and the taps of octal 133. Output B uses octal 171. Here d1 is the previous bit and d6 the oldest. A taps the current bit, d2, d3, d5 and d6. B taps the current bit, d1, d2, d3 and d6. At rate 1/2 every input bit yields A and then B.
- R3: The encoder history is cleared when a start bit is taken, so each packet encodes as if it were the only one sent.
- R4: After the bit flagged as end, six zero bits are encoded and punctured like data. At rate 1/2 a packet of N bits therefore yields 2(N+6) coded bits.
- R5: Rate code 1 selects 2/3. Over each pair of steps it keeps A, B of the first step and A of the second, and drops B of the second.
- R6: Rate code 2 selects 3/4. Over each group of three steps it keeps A, B of the first step, A of the second and B of the third.
- R7: The rate code is sampled only with the start bit, and the puncturing phase restarts there. Rate codes on later bits have no effect. Code 0 and code 3 both select rate 1/2.
- R8: out_last is 1 on exactly one coded bit per packet, the last one.
- R9: Stalls on out_ready lose and repeat no coded bit. While out_valid is 1 and out_ready is 0, out_bit and out_last hold.
- R10: When no packet is open, a bit taken without the start flag is discarded and produces no output.
- R11: in_ready is 0 while tail bits are being flushed, and whenever the output register has no room for the next group of coded bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Block takes the input bit this cycle |
| in_bit | input | 1 | Scrambled payload bit |
| in_sop | input | 1 | First bit of a packet |
| in_eop | input | 1 | Last bit of a packet |
| in_rate | input | 2 | Rate code: 0 or 3 for 1/2, 1 for 2/3, 2 for 3/4 |
| out_valid | output | 1 | Coded bit is valid |
| out_ready | input | 1 | Downstream takes the coded bit |
| out_bit | output | 1 | Coded bit |
| out_last | output | 1 | Final coded bit of the packet |

## Verification
The code taps and the A-before-B order are pinned down by a single one bit followed only by tail. That packet must give the impulse response of both generators, interleaved. Bit patterns run at each rate show the three puncturing patterns and where each one restarts. Two packets sent back to back show that the encoder history is cleared at the packet boundary. The same packet is replayed with random stalls on out_ready to show that none are lost or repeated. Extra cases cover rate codes changed in mid-packet, the unused rate code, and a stray bit outside any packet, each of which must leave the output unchanged.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

    typedef enum logic [1:0] {
        RATE_1_2 = 2'd0,
        RATE_2_3 = 2'd1,
        RATE_3_4 = 2'd2
    } rate_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_TAIL = 2'd2
    } mode_e;

    // coded bits produced by the mother code per input bit
    localparam int N_MOTHER = 2;
    localparam int CW       = $clog2(N_MOTHER + 1);

    function automatic rate_e decode_rate(input logic [1:0] code);
        case (code)
            2'd1:    return RATE_2_3;
            2'd2:    return RATE_3_4;
            default: return RATE_1_2;
        endcase
    endfunction

endpackage

// File: rtl/conv_gen.sv
module conv_gen #(
    parameter int         K   = 7,
    parameter logic [K-1:0] G_A = 7'o133,
    parameter logic [K-1:0] G_B = 7'o171
) (
    input  logic         u,
    input  logic [K-2:0] sr,
    output logic         a,
    output logic         b,
    output logic [K-2:0] sr_next
);
    // window MSB is the current bit; sr MSB is the most recent history bit
    logic [K-1:0] win;

    always_comb begin
        win     = {u, sr};
        a       = ^(win & G_A);
        b       = ^(win & G_B);
        sr_next = {u, sr[K-2:1]};
    end

endmodule

// File: rtl/punct_map.sv
module punct_map
    import conv_enc_pkg::*;
(
    input  rate_e       rate,
    input  logic [1:0]  phase,
    output logic        keep_a,
    output logic        keep_b,
    output logic [1:0]  phase_next
);
    logic [1:0] period;

    always_comb begin
        keep_a = 1'b1;
        keep_b = 1'b1;
        period = 2'd1;
        case (rate)
            RATE_2_3: begin
                period = 2'd2;
                if (phase == 2'd1) keep_b = 1'b0;
            end
            RATE_3_4: begin
                period = 2'd3;
                if (phase == 2'd1)      keep_b = 1'b0;
                else if (phase == 2'd2) keep_a = 1'b0;
            end
            default: ;
        endcase
        phase_next = (phase >= period - 2'd1) ? 2'd0 : phase + 2'd1;
    end

endmodule

// File: rtl/coded_obuf.sv
module coded_obuf
    import conv_enc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [N_MOTHER-1:0] ld_bits,
    input  logic [N_MOTHER-1:0] ld_last,
    input  logic [CW-1:0]       ld_cnt,
    input  logic                out_ready,
    output logic                out_valid,
    output logic                out_bit,
    output logic                out_last,
    output logic                space
);
    typedef struct packed {
        logic [N_MOTHER-1:0] bits;
        logic [N_MOTHER-1:0] lasts;
        logic [CW-1:0]       cnt;
    } obuf_t;

    obuf_t q, d;
    logic  pop;

    always_comb begin
        pop   = (q.cnt != '0) && out_ready;
        space = (q.cnt == '0) || ((q.cnt == CW'(1)) && out_ready);
        d     = q;
        if (load) begin
            d.bits  = ld_bits;
            d.lasts = ld_last;
            d.cnt   = ld_cnt;
        end else if (pop) begin
            d.bits  = q.bits >> 1;
            d.lasts = q.lasts >> 1;
            d.cnt   = q.cnt - CW'(1);
        end
        out_valid = (q.cnt != '0);
        out_bit   = q.bits[0];
        out_last  = q.lasts[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ((q.cnt == '0) || ((q.cnt == CW'(1)) && out_ready)));

    p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

    p_last_is_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (q.cnt == CW'(1)));

endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc
    import conv_enc_pkg::*;
#(
    parameter int           K   = 7,
    parameter logic [K-1:0] G_A = 7'o133,
    parameter logic [K-1:0] G_B = 7'o171
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_bit,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic [1:0] in_rate,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_bit,
    output logic       out_last
);
    localparam int TAIL_LEN = K - 1;
    localparam int TW       = (TAIL_LEN > 1) ? $clog2(TAIL_LEN) : 1;

    typedef struct packed {
        mode_e         mode;
        rate_e         rate;
        logic [K-2:0]  sr;
        logic [1:0]    phase;
        logic [TW-1:0] tcnt;
    } st_t;

    st_t q, d;

    logic                space;
    logic                fire;
    logic                step;
    logic                last_step;
    logic                u;
    rate_e               cur_rate;
    logic [K-2:0]        cur_sr;
    logic [1:0]          cur_phase;
    logic                enc_a, enc_b;
    logic [K-2:0]        sr_next;
    logic                keep_a, keep_b;
    logic [1:0]          phase_next;
    logic                load;
    logic [N_MOTHER-1:0] ld_bits;
    logic [N_MOTHER-1:0] ld_last;
    logic [CW-1:0]       ld_cnt;

    // step selection: which bit enters the encoder and from what context
    always_comb begin
        in_ready  = space && (q.mode != ST_TAIL);
        fire      = in_valid && in_ready;
        u         = in_bit;
        cur_rate  = q.rate;
        cur_sr    = q.sr;
        cur_phase = q.phase;
        step      = 1'b0;
        last_step = 1'b0;
        case (q.mode)
            ST_IDLE: begin
                cur_rate  = decode_rate(in_rate);
                cur_sr    = '0;
                cur_phase = '0;
                step      = fire && in_sop;
            end
            ST_DATA: step = fire;
            ST_TAIL: begin
                u         = 1'b0;
                step      = space;
                last_step = space && (q.tcnt == TW'(TAIL_LEN - 1));
            end
            default: ;
        endcase
    end

    conv_gen #(.K(K), .G_A(G_A), .G_B(G_B)) i_gen (
        .u       (u),
        .sr      (cur_sr),
        .a       (enc_a),
        .b       (enc_b),
        .sr_next (sr_next)
    );

    punct_map i_map (
        .rate       (cur_rate),
        .phase      (cur_phase),
        .keep_a     (keep_a),
        .keep_b     (keep_b),
        .phase_next (phase_next)
    );

    // next state and output group packing
    always_comb begin
        d = q;
        case (q.mode)
            ST_IDLE: if (step) begin
                d.rate = cur_rate;
                d.mode = in_eop ? ST_TAIL : ST_DATA;
                d.tcnt = '0;
            end
            ST_DATA: if (step && in_eop) begin
                d.mode = ST_TAIL;
                d.tcnt = '0;
            end
            ST_TAIL: if (step) begin
                if (last_step) d.mode = ST_IDLE;
                else           d.tcnt = q.tcnt + TW'(1);
            end
            default: d.mode = ST_IDLE;
        endcase
        if (step) begin
            d.sr    = sr_next;
            d.phase = phase_next;
        end

        load = step;
        if (keep_a && keep_b) begin
            ld_bits = {enc_b, enc_a};
            ld_last = {last_step, 1'b0};
            ld_cnt  = CW'(2);
        end else if (keep_a) begin
            ld_bits = {1'b0, enc_a};
            ld_last = {1'b0, last_step};
            ld_cnt  = CW'(1);
        end else begin
            ld_bits = {1'b0, enc_b};
            ld_last = {1'b0, last_step};
            ld_cnt  = CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= ST_IDLE;
            q.rate <= RATE_1_2;
        end else begin
            q <= d;
        end
    end

    coded_obuf i_obuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_bits   (ld_bits),
        .ld_last   (ld_last),
        .ld_cnt    (ld_cnt),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last),
        .space     (space)
    );

    p_sop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == ST_IDLE && in_valid && in_ready && in_sop) |=> (q.sr[K-3:0] == '0));

    p_tail_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == ST_TAIL) |-> (q.tcnt <= TW'(TAIL_LEN - 1)));

    p_phase_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rate == RATE_1_2) |-> (q.phase == 2'd0));

    p_phase_twothird_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rate == RATE_2_3) |-> (q.phase <= 2'd1));

    p_phase_threequarter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rate == RATE_3_4) |-> (q.phase <= 2'd2));

    p_rate_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode != ST_IDLE) |=> $stable(q.rate));

    p_stray_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == ST_IDLE && in_valid && in_ready && !in_sop) |=> (q.mode == ST_IDLE));

endmodule

// File: tb/test_conv_punct_enc.sv
module test_conv_punct_enc;

    typedef bit bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic [1:0] in_rate = 2'd0;
    logic       out_ready = 1'b1;
    logic       in_ready, out_valid, out_bit, out_last;

    always #4 clk = ~clk;

    conv_punct_enc i_conv_punct_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_rate   (in_rate),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    int       n_chk  = 0;
    int       n_fail = 0;
    int       cyc    = 0;
    bit       bp     = 1'b0;
    logic [7:0] lf   = 8'h5a;
    bq_t      got;
    bq_t      gotl;

    // downstream pacing, changed after each edge
    always @(posedge clk) begin
        #2;
        if (bp) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            out_ready = lf[0];
        end else begin
            out_ready = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            got.push_back(out_bit);
            gotl.push_back(out_last);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic bq_t model(input bq_t bits, input int rate);
        bit [5:0] s = '0;   // s[0]=d1 ... s[5]=d6
        int ph = 0;
        int per = (rate == 1) ? 2 : (rate == 2) ? 3 : 1;
        bq_t o;
        bq_t all = bits;
        repeat (6) all.push_back(1'b0);
        foreach (all[i]) begin
            bit u = all[i];
            bit a = u ^ s[1] ^ s[2] ^ s[4] ^ s[5];
            bit b = u ^ s[0] ^ s[1] ^ s[2] ^ s[5];
            bit ka = !(rate == 2 && ph == 2);
            bit kb = !((rate == 1 || rate == 2) && ph == 1);
            if (ka) o.push_back(a);
            if (kb) o.push_back(b);
            s  = {s[4:0], u};
            ph = (ph + 1) % per;
        end
        return o;
    endfunction

    function automatic bq_t mk_last(input int n);
        bq_t l;
        for (int i = 0; i < n; i++) l.push_back(i == n - 1);
        return l;
    endfunction

    function automatic bq_t pat(input int n, input int seed);
        bq_t p;
        int  x = seed;
        for (int i = 0; i < n; i++) begin
            x = (x * 1103515245 + 12345) & 32'h7fffffff;
            p.push_back(x[16]);
        end
        return p;
    endfunction

    task automatic send_raw(input bit b, input bit sop, input bit eop, input logic [1:0] rate);
        @(negedge clk);
        in_valid = 1'b1;
        in_bit   = b;
        in_sop   = sop;
        in_eop   = eop;
        in_rate  = rate;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic send(input bq_t bits, input logic [1:0] rate, input logic [1:0] other);
        foreach (bits[i])
            send_raw(bits[i], i == 0, i == bits.size() - 1, (i == 0) ? rate : other);
    endtask

    task automatic wait_out(input int n);
        while (got.size() < n) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    task automatic cmp(input bq_t exp, input bq_t expl, input string req);
        chk(got.size() == exp.size(), req, "coded length", got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++) begin
            chk(got[i] == exp[i], req, $sformatf("bit %0d", i), got[i], exp[i]);
            chk(gotl[i] == expl[i], "R8", $sformatf("last flag %0d", i), gotl[i], expl[i]);
        end
        got.delete();
        gotl.delete();
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_impulse;   // R2 R4: generator impulse responses, A first
        bq_t e = '{1,1, 0,1, 1,1, 1,1, 0,0, 1,0, 1,1};
        send('{1'b1}, 2'd0, 2'd0);
        wait_out(14);
        cmp(e, mk_last(14), "R2");
    endtask

    task automatic t_rate23;    // R5
        bq_t p = pat(10, 7);
        bq_t e = model(p, 1);
        send(p, 2'd1, 2'd1);
        wait_out(24);
        chk(e.size() == 24, "R5", "model length", e.size(), 24);
        cmp(e, mk_last(e.size()), "R5");
    endtask

    task automatic t_rate34;    // R6
        bq_t p = pat(11, 21);
        bq_t e = model(p, 2);
        send(p, 2'd2, 2'd2);
        wait_out(23);
        chk(e.size() == 23, "R6", "model length", e.size(), 23);
        cmp(e, mk_last(e.size()), "R6");
    endtask

    task automatic t_tail_ready;  // R11 R4
        bq_t p = pat(5, 3);
        bq_t e = model(p, 0);
        send(p, 2'd0, 2'd0);
        #1;
        chk(in_ready == 1'b0, "R11", "in_ready during tail flush", in_ready, 0);
        wait_out(22);
        chk(e.size() == 22, "R4", "rate 1/2 length", e.size(), 22);
        cmp(e, mk_last(e.size()), "R4");
    endtask

    task automatic t_backpressure;  // R9
        bq_t p = pat(20, 99);
        bq_t e = model(p, 2);
        bp = 1'b1;
        send(p, 2'd2, 2'd2);
        wait_out(e.size());
        bp = 1'b0;
        cmp(e, mk_last(e.size()), "R9");
    endtask

    task automatic t_rate_latch;   // R7
        bq_t p = pat(9, 55);
        bq_t e = model(p, 0);
        send(p, 2'd0, 2'd2);
        wait_out(e.size());
        cmp(e, mk_last(e.size()), "R7");
        send(p, 2'd3, 2'd1);
        wait_out(e.size());
        cmp(e, mk_last(e.size()), "R7");
    endtask

    task automatic t_back2back;    // R3
        bq_t p1 = pat(7, 11);
        bq_t p2 = pat(8, 12);
        bq_t e  = model(p1, 1);
        bq_t el = mk_last(e.size());
        bq_t e2 = model(p2, 2);
        bq_t l2 = mk_last(e2.size());
        foreach (e2[i]) begin
            e.push_back(e2[i]);
            el.push_back(l2[i]);
        end
        send(p1, 2'd1, 2'd1);
        send(p2, 2'd2, 2'd2);
        wait_out(e.size());
        cmp(e, el, "R3");
    endtask

    task automatic t_stray;        // R10
        bq_t p = pat(6, 42);
        bq_t e = model(p, 1);
        send_raw(1'b1, 1'b0, 1'b0, 2'd2);
        send_raw(1'b1, 1'b0, 1'b1, 2'd2);
        repeat (20) @(negedge clk);
        chk(got.size() == 0, "R10", "output count after stray bits", got.size(), 0);
        send(p, 2'd1, 2'd1);
        wait_out(e.size());
        cmp(e, mk_last(e.size()), "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_impulse();
        t_rate23();
        t_rate34();
        t_tail_ready();
        t_backpressure();
        t_rate_latch();
        t_back2back();
        t_stray();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule